// File: doc/BRIEF.md
# Multi-Channel Ultrasonic Echo Timer

This peripheral sits on an 8-bit ring bus and serves a group of seven ultrasonic range sensors that share one trigger line. At a programmable interval it raises the trigger for ten microsecond strobes. It then measures, in parallel, how long each sensor holds its echo line high, counting microsecond strobes from the echo's rising edge to its falling edge. When the next interval expires, the seven counts are frozen into holding registers and the round starts over.

The bus controller reads results through byte registers and polls the block to learn whether a finished round is waiting. A poll answers with the number of result bytes, or zero when nothing is pending. Timing comes from single-cycle strobe inputs at 1 µs and 10 ms, which are synchronous to the system clock. When the block is not selected, bus data flows through it unchanged so that the next node on the ring receives it.

Top module: `echo_timer_ring`

## Requirements
- R1: After reset the trigger output is low, a poll answers 0, every result register reads 0 and the interval register reads 0.
- R2: While `bus_sel` is low, `bus_dout` equals `bus_din` in the same cycle.
- R3: A register access (`bus_sel`=1, `bus_tag`=1, `bus_we`=1) to address 14 loads the low 4 bits of `bus_din` as the interval. Address 14 then reads back as the interval in bits 3:0 with zeros above. The write also restarts the wait for the next trigger.
- R4: While the interval is 0, the trigger output stays low whatever strobes arrive.
- R5: With interval N>0, the trigger output goes high one cycle after the N-th 10 ms strobe. It falls one cycle after the 10th 1 µs strobe seen while it is high.
- R6: Each channel counts the 1 µs strobes that fall between its echo's rising and falling edges, independently of the other channels. All counts clear when the trigger rises.
- R7: A channel count stops at 0xFFFF instead of wrapping.
- R8: N 10 ms strobes after the trigger falls, all counts are captured into holding registers and a new trigger starts. Channel k (0..6) reads as its high byte at address 2k and its low byte at address 2k+1.
- R9: A poll (`bus_sel`=1, `bus_tag`=0) answers 14 once a capture has occurred and 0 otherwise. A read of address 13 clears the pending flag, except in the cycle of a capture, where the capture wins.
- R10: `bus_ack` is high exactly for register accesses to addresses 0 to 14. `bus_stall` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | This node is addressed (access or poll) |
| bus_tag | input | 1 | 1 = register access, 0 = poll |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_din | input | 8 | Ring data arriving at this node |
| bus_dout | output | 8 | Ring data leaving this node |
| bus_ack | output | 1 | Access claimed and completed |
| bus_stall | output | 1 | More cycles needed (always 0) |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| tick_10ms | input | 1 | One-cycle strobe every 10 ms |
| echo_in | input | 7 | Echo lines of the seven sensors, asynchronous |
| trig_out | output | 1 | Shared trigger to all sensors |

## Verification
A capture of finished counts and the host's read of the last result byte can fall in the same clock cycle. The first sets the pending flag and the second clears it. The bench provokes this by holding a read of address 13 for exactly the one cycle in which the capture pulse is active, which is the cycle after the expiring 10 ms strobe. A subsequent poll must then answer 14, and the registers must show the new round's values.

// File: rtl/echo_pkg.sv
package echo_pkg;
  typedef enum logic [1:0] {
    SEQ_WAIT   = 2'd0,
    SEQ_TRIG   = 2'd1,
    SEQ_LISTEN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/echo_channel.sv
module echo_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_us,
  input  logic             enable,
  input  logic             clear,
  input  logic             echo_raw,
  output logic [CNT_W-1:0] count
);
  logic sync1, sync2, sync3, running;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      sync3   <= 1'b0;
      running <= 1'b0;
      count   <= '0;
    end else begin
      sync1 <= echo_raw;
      sync2 <= sync1;
      sync3 <= sync2;
      if (clear) begin
        running <= 1'b0;
        count   <= '0;
      end else if (enable && sync2 && !sync3) begin
        running <= 1'b1;
        count   <= '0;
      end else if (!sync2 && sync3) begin
        running <= 1'b0;
      end else if (running && enable && tick_us && (count != '1)) begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/echo_sequencer.sv
module echo_sequencer
  import echo_pkg::*;
#(
  parameter int RATE_W  = 4,
  parameter int TRIG_US = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_us,
  input  logic              tick_10ms,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_in,
  output logic [RATE_W-1:0] rate,
  output logic              trig,
  output logic              listen,
  output logic              clear,
  output logic              capture
);
  localparam int UCNT_W = (TRIG_US > 1) ? $clog2(TRIG_US) : 1;

  seq_state_t        state;
  logic [RATE_W-1:0] icnt;
  logic [UCNT_W-1:0] ucnt;
  logic              expire;

  assign expire = tick_10ms && (rate != '0) && (icnt <= RATE_W'(1));
  assign listen = (state == SEQ_LISTEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_WAIT;
      rate    <= '0;
      icnt    <= '0;
      ucnt    <= '0;
      trig    <= 1'b0;
      clear   <= 1'b0;
      capture <= 1'b0;
    end else begin
      clear   <= 1'b0;
      capture <= 1'b0;
      if (rate_wr) begin
        rate  <= rate_in;
        icnt  <= rate_in;
        trig  <= 1'b0;
        state <= SEQ_WAIT;
      end else begin
        case (state)
          SEQ_WAIT: begin
            if (expire) begin
              state <= SEQ_TRIG;
              trig  <= 1'b1;
              clear <= 1'b1;
              ucnt  <= '0;
            end else if (tick_10ms && icnt != '0) begin
              icnt <= icnt - 1'b1;
            end
          end
          SEQ_TRIG: begin
            if (tick_us) begin
              if (ucnt == UCNT_W'(TRIG_US - 1)) begin
                state <= SEQ_LISTEN;
                trig  <= 1'b0;
                icnt  <= rate;
              end else begin
                ucnt <= ucnt + 1'b1;
              end
            end
          end
          SEQ_LISTEN: begin
            if (expire) begin
              capture <= 1'b1;
              state   <= SEQ_TRIG;
              trig    <= 1'b1;
              clear   <= 1'b1;
              ucnt    <= '0;
            end else if (tick_10ms && icnt != '0) begin
              icnt <= icnt - 1'b1;
            end
          end
          default: state <= SEQ_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/echo_bus_port.sv
module echo_bus_port #(
  parameter int NUM_CH = 7,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int RATE_W = 4,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_sel,
  input  logic                         bus_tag,
  input  logic                         bus_we,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_din,
  input  logic                         capture,
  input  logic [NUM_CH-1:0][CNT_W-1:0] counts,
  input  logic [RATE_W-1:0]            rate,
  output logic [DATA_W-1:0]            bus_dout,
  output logic                         bus_ack,
  output logic                         bus_stall,
  output logic                         rate_wr,
  output logic                         data_ready
);
  localparam int NUM_REG   = 2 * NUM_CH;
  localparam int RATE_ADDR = NUM_REG;

  logic [CNT_W-1:0] hold [NUM_CH];
  logic             reg_acc, last_rd;
  logic [CNT_W-1:0] word;

  assign reg_acc   = bus_sel && bus_tag;
  assign bus_ack   = reg_acc && (bus_addr <= ADDR_W'(RATE_ADDR));
  assign bus_stall = 1'b0;
  assign rate_wr   = reg_acc && bus_we && (bus_addr == ADDR_W'(RATE_ADDR));
  assign last_rd   = reg_acc && !bus_we && (bus_addr == ADDR_W'(NUM_REG - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_ready <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) hold[i] <= '0;
    end else begin
      if (capture) begin
        data_ready <= 1'b1;
        for (int i = 0; i < NUM_CH; i++) hold[i] <= counts[i];
      end else if (last_rd) begin
        data_ready <= 1'b0;
      end
    end
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (bus_addr[ADDR_W-1:1] == (ADDR_W-1)'(i)) word = hold[i];
  end

  always_comb begin
    if (!bus_sel)
      bus_dout = bus_din;
    else if (!bus_tag)
      bus_dout = data_ready ? DATA_W'(NUM_REG) : '0;
    else if (bus_addr < ADDR_W'(NUM_REG))
      bus_dout = bus_addr[0] ? word[DATA_W-1:0] : word[CNT_W-1:DATA_W];
    else if (bus_addr == ADDR_W'(RATE_ADDR))
      bus_dout = {{(DATA_W-RATE_W){1'b0}}, rate};
    else
      bus_dout = '0;
  end
endmodule

// File: rtl/echo_timer_ring.sv
module echo_timer_ring #(
  parameter int NUM_CH  = 7,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int RATE_W  = 4,
  parameter int TRIG_US = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_tag,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_ack,
  output logic              bus_stall,
  input  logic              tick_us,
  input  logic              tick_10ms,
  input  logic [NUM_CH-1:0] echo_in,
  output logic              trig_out
);
  localparam int CNT_W = 2 * DATA_W;

  logic [RATE_W-1:0]            rate;
  logic                         rate_wr, listen, ch_clear, capture, data_ready;
  logic [NUM_CH-1:0][CNT_W-1:0] counts;

  echo_sequencer #(.RATE_W(RATE_W), .TRIG_US(TRIG_US)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick_us   (tick_us),
    .tick_10ms (tick_10ms),
    .rate_wr   (rate_wr),
    .rate_in   (bus_din[RATE_W-1:0]),
    .rate      (rate),
    .trig      (trig_out),
    .listen    (listen),
    .clear     (ch_clear),
    .capture   (capture)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    echo_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick_us  (tick_us),
      .enable   (listen),
      .clear    (ch_clear),
      .echo_raw (echo_in[g]),
      .count    (counts[g])
    );
  end

  echo_bus_port #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RATE_W(RATE_W)
  ) u_port (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_tag    (bus_tag),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_din    (bus_din),
    .capture    (capture),
    .counts     (counts),
    .rate       (rate),
    .bus_dout   (bus_dout),
    .bus_ack    (bus_ack),
    .bus_stall  (bus_stall),
    .rate_wr    (rate_wr),
    .data_ready (data_ready)
  );
endmodule

// File: rtl/echo_timer_ring_chk.sv
module echo_timer_ring_chk #(
  parameter int NUM_CH = 7,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_tag,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_din,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_ack,
  input logic              tick_us,
  input logic              tick_10ms,
  input logic              trig_out,
  input logic [RATE_W-1:0] rate,
  input logic              rate_wr,
  input logic              capture,
  input logic              data_ready
);
  AST_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |-> bus_dout == bus_din); // R2
  AST_ACK_RANGE: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> (bus_sel && bus_tag && bus_addr <= ADDR_W'(2*NUM_CH))); // R10
  AST_RATE0_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rate == '0) |-> !trig_out); // R4
  AST_TRIG_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_out) |-> $past(tick_10ms)); // R5
  AST_TRIG_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(trig_out) |-> ($past(tick_us) || $past(rate_wr))); // R5
  AST_POLL_CODE: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_tag) |-> (bus_dout == '0 || bus_dout == DATA_W'(2*NUM_CH))); // R9
  AST_READY_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $past(capture)); // R9
  AST_READY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(data_ready) |-> $past(bus_sel && bus_tag && !bus_we &&
                                bus_addr == ADDR_W'(2*NUM_CH-1))); // R9
endmodule

bind echo_timer_ring echo_timer_ring_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RATE_W(RATE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_tag    (bus_tag),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_din    (bus_din),
  .bus_dout   (bus_dout),
  .bus_ack    (bus_ack),
  .tick_us    (tick_us),
  .tick_10ms  (tick_10ms),
  .trig_out   (trig_out),
  .rate       (rate),
  .rate_wr    (rate_wr),
  .capture    (capture),
  .data_ready (data_ready)
);

// File: tb/echo_timer_ring_tb.sv
module echo_timer_ring_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 0, bus_tag = 0, bus_we = 0;
  logic [7:0] bus_addr = 0, bus_din = 0;
  logic [7:0] bus_dout;
  logic       bus_ack, bus_stall;
  logic       tick_us = 0, tick_10ms = 0;
  logic [6:0] echo_in = 0;
  logic       trig_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  echo_timer_ring u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_tag(bus_tag), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_ack(bus_ack),
    .bus_stall(bus_stall), .tick_us(tick_us), .tick_10ms(tick_10ms),
    .echo_in(echo_in), .trig_out(trig_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input int data);
    @(negedge clk);
    bus_sel = 1; bus_tag = 1; bus_we = 1; bus_addr = 8'(addr); bus_din = 8'(data);
    @(negedge clk);
    bus_sel = 0; bus_tag = 0; bus_we = 0; bus_din = 0;
  endtask

  task automatic bus_read(input int addr, output int data, output int ack);
    @(negedge clk);
    bus_sel = 1; bus_tag = 1; bus_we = 0; bus_addr = 8'(addr);
    #1;
    data = int'(bus_dout);
    ack  = int'(bus_ack);
    @(negedge clk);
    bus_sel = 0; bus_tag = 0;
  endtask

  task automatic bus_poll(output int data, output int ack);
    @(negedge clk);
    bus_sel = 1; bus_tag = 0; bus_we = 0; bus_addr = 0;
    #1;
    data = int'(bus_dout);
    ack  = int'(bus_ack);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pulse_us(input int n);
    repeat (n) begin
      @(negedge clk); tick_us = 1;
      @(negedge clk); tick_us = 0;
    end
  endtask

  task automatic pulse_10ms();
    @(negedge clk); tick_10ms = 1;
    @(negedge clk); tick_10ms = 0;
  endtask

  task automatic trig_check(input string req, input int exp);
    @(negedge clk); #1;
    chk(req, "trig_out", int'(trig_out), exp);
  endtask

  task automatic test_reset();
    int d, a;
    trig_check("R1", 0);
    bus_poll(d, a);
    chk("R1", "poll after reset", d, 0);
    for (int r = 0; r <= 14; r++) begin
      bus_read(r, d, a);
      chk("R1", $sformatf("reg %0d after reset", r), d, 0);
    end
  endtask

  task automatic test_passthru();
    @(negedge clk);
    bus_sel = 0; bus_tag = 1; bus_we = 1; bus_addr = 14; bus_din = 8'hA5; #1;
    chk("R2", "unselected data A5", int'(bus_dout), 'hA5);
    @(negedge clk);
    bus_tag = 0; bus_we = 0; bus_addr = 3; bus_din = 8'h3C; #1;
    chk("R2", "unselected data 3C", int'(bus_dout), 'h3C);
    @(negedge clk);
    bus_din = 0;
    trig_check("R2", 0);
  endtask

  task automatic test_ack();
    int d, a;
    bus_read(14, d, a); chk("R10", "ack addr 14", a, 1);
    bus_read(0, d, a);  chk("R10", "ack addr 0", a, 1);
    bus_read(15, d, a); chk("R10", "ack addr 15", a, 0);
    chk("R10", "data addr 15", d, 0);
    bus_poll(d, a);     chk("R10", "ack on poll", a, 0);
    chk("R10", "stall", int'(bus_stall), 0);
  endtask

  task automatic test_rate_reg();
    int d, a;
    bus_write(14, 'hF7);
    bus_read(14, d, a);
    chk("R3", "interval readback low nibble", d, 'h07);
    bus_write(14, 0);
    repeat (3) begin
      pulse_10ms();
      trig_check("R4", 0);
    end
  endtask

  task automatic test_round1();
    int nv[7] = '{1, 2, 3, 5, 8, 13, 21};
    int d, a;
    bus_write(14, 2);
    pulse_10ms();
    trig_check("R5", 0);
    pulse_10ms();
    trig_check("R5", 1);
    pulse_us(9);
    trig_check("R5", 1);
    pulse_us(1);
    trig_check("R5", 0);
    @(negedge clk); echo_in = 7'h7F;
    repeat (5) @(negedge clk);
    for (int p = 1; p <= 21; p++) begin
      pulse_us(1);
      for (int k = 0; k < 7; k++) if (nv[k] == p) echo_in[k] = 1'b0;
      repeat (5) @(negedge clk);
    end
    pulse_10ms();
    bus_poll(d, a);
    chk("R9", "poll before window end", d, 0);
    pulse_10ms();
    bus_poll(d, a);
    chk("R9", "poll after capture", d, 14);
    trig_check("R8", 1);
    for (int k = 0; k < 7; k++) begin
      bus_read(2*k, d, a);
      chk("R6", $sformatf("ch%0d high byte", k), d, nv[k] >> 8);
      bus_read(2*k+1, d, a);
      chk("R8", $sformatf("ch%0d low byte", k), d, nv[k] & 'hFF);
    end
    bus_poll(d, a);
    chk("R9", "poll after reading reg 13", d, 0);
  endtask

  task automatic test_round2_collision();
    int d, a;
    pulse_us(10);
    trig_check("R5", 0);
    @(negedge clk); echo_in[0] = 1; echo_in[6] = 1;
    repeat (5) @(negedge clk);
    tick_us = 1;
    repeat (300) @(negedge clk);
    tick_us = 0; echo_in[0] = 0;
    repeat (5) @(negedge clk);
    tick_us = 1;
    repeat (70000) @(negedge clk);
    tick_us = 0; echo_in[6] = 0;
    repeat (5) @(negedge clk);
    pulse_10ms();
    @(negedge clk); tick_10ms = 1;
    @(negedge clk); tick_10ms = 0;
    bus_sel = 1; bus_tag = 1; bus_we = 0; bus_addr = 13;
    @(negedge clk); bus_sel = 0; bus_tag = 0;
    bus_poll(d, a);
    chk("R9", "capture wins over reg 13 read", d, 14);
    bus_read(0, d, a); chk("R8", "ch0 high byte", d, 'h01);
    bus_read(1, d, a); chk("R8", "ch0 low byte", d, 'h2C);
    for (int k = 1; k < 6; k++) begin
      bus_read(2*k, d, a);   chk("R6", $sformatf("ch%0d cleared hi", k), d, 0);
      bus_read(2*k+1, d, a); chk("R6", $sformatf("ch%0d cleared lo", k), d, 0);
    end
    bus_read(12, d, a); chk("R7", "ch6 saturated hi", d, 'hFF);
    bus_read(13, d, a); chk("R7", "ch6 saturated lo", d, 'hFF);
    bus_poll(d, a);
    chk("R9", "poll cleared", d, 0);
  endtask

  task automatic test_restart();
    bus_write(14, 1);
    trig_check("R3", 0);
    pulse_10ms();
    trig_check("R3", 1);
    bus_write(14, 0);
    trig_check("R4", 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    test_reset();
    test_passthru();
    test_ack();
    test_rate_reg();
    test_round1();
    test_round2_collision();
    test_restart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule